// File: doc/BRIEF.md
# Redundant Commit Checker

This block sits at the retirement point of a fast speculative core and re-does the work of every instruction the core claims to have completed. The core hands over, in program order and through a valid/ready handshake, one record per instruction: its PC, instruction word, both source operand values, result, memory address and next PC. The checker fetches the instruction word for its own expected PC, reads the operands from its own architectural register file, and executes the instruction on a small in-order datapath. It then compares all six fields against the core's record.

When every field agrees, the checker commits the result to its register file. When any field disagrees, it commits its own result instead and reports which fields were wrong. In the next cycle it pulses a restart that carries its own next PC, and input is blocked for that cycle. A watchdog raises a fault when the core stops handing over instructions. The core, the caches and branch prediction are outside the block.

Top module: `rcc_commit_checker`

## Requirements
- R1: While no restart is pending, `in_ready_o` is high. Every accepted record (`in_valid_i` and `in_ready_o` high at a clock edge) produces exactly one `commit_valid_o` pulse in the following cycle. There is no commit pulse without an accepted record.
- R2: The instruction word is split into opcode [15:12], rd [11:9], rs1 [8:6] and rs2 [5:3], with a 6-bit signed immediate in [5:0]. Let a = reg[rs1] and b = reg[rs2]. The opcodes behave as follows:
  - 0: rd = a+b
  - 1: rd = a-b
  - 2: rd = a&b
  - 3: rd = a^b
  - 4: rd = a+sext(imm)
  - 5: store. No register write; result = b, address = a.
  - 6: branch if a is nonzero. Next PC = pc+sext(imm), otherwise pc+1. Result 0.
  - 7 to 15: no operation, result 0.
  
  The address is 0 for every opcode other than the store, and the next PC is pc+1 for every opcode other than the branch. `commit_data_o` shows the checker's result.
- R3: Operands are taken from the checker's own register file. Register 0 reads as zero. A write aimed at register 0 is dropped, and `commit_we_o` stays low for it.
- R4: When all six fields agree, `commit_mismatch_o` is 0, `commit_fields_o` is 0 and no restart follows.
- R5: Each disagreeing field sets its bit in `commit_fields_o`: bit 0 PC, bit 1 instruction, bit 2 operands, bit 3 result, bit 4 address, bit 5 next PC. `commit_mismatch_o` is then 1, and the checker's own result is still written.
- R6: In the cycle that shows a mismatching commit, `restart_o` is high for exactly one cycle. `restart_pc_o` equals the checker's own next PC, and `in_ready_o` is low in that cycle.
- R7: The expected PC starts at RESET_PC (0) and moves to the checker's own next PC on every accepted record. `fetch_pc_o` shows it.
- R8: `wdog_fault_o` rises after WDOG_LIMIT consecutive clock edges without an accepted record. It clears on the edge that accepts one.
- R9: After reset, `in_ready_o` is 1, `commit_valid_o`, `restart_o` and `wdog_fault_o` are 0, and all registers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| in_valid_i | input | 1 | core record valid |
| in_ready_o | output | 1 | checker can accept a record |
| in_pc_i | input | PC_W | core PC |
| in_instr_i | input | 16 | core instruction word |
| in_op_a_i | input | XLEN | core first operand |
| in_op_b_i | input | XLEN | core second operand |
| in_result_i | input | XLEN | core result |
| in_addr_i | input | XLEN | core memory address |
| in_next_pc_i | input | PC_W | core next PC |
| fetch_pc_o | output | PC_W | checker's expected PC, used as fetch address |
| fetch_instr_i | input | 16 | instruction word at fetch_pc_o |
| commit_valid_o | output | 1 | commit pulse |
| commit_we_o | output | 1 | commit wrote a register |
| commit_rd_o | output | 3 | destination register |
| commit_data_o | output | XLEN | checker's result |
| commit_mismatch_o | output | 1 | some field disagreed |
| commit_fields_o | output | 6 | per-field disagreement |
| restart_o | output | 1 | core restart pulse |
| restart_pc_o | output | PC_W | PC the core restarts from |
| wdog_fault_o | output | 1 | core stopped retiring |

## Verification
The bench sweeps every opcode against every combination of destination and source registers, with register contents that keep changing, and separately sweeps all 64 immediates. This separates errors in the operation, in operand routing and in the handling of register 0. Corruption is injected into each of the six fields in turn over several opcodes; each case must flag exactly that field bit, keep the checker's own result and restart at the correct PC. The watchdog is tested one cycle before its limit and at its limit, which pins down the exact count.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int INSTR_W = 16;
  localparam int REG_AW  = 3;
  localparam int NREGS   = 1 << REG_AW;
  localparam int IMM_W   = 6;
  localparam int NFIELDS = 6;

  localparam logic [3:0] OPC_ADD  = 4'd0;
  localparam logic [3:0] OPC_SUB  = 4'd1;
  localparam logic [3:0] OPC_AND  = 4'd2;
  localparam logic [3:0] OPC_XOR  = 4'd3;
  localparam logic [3:0] OPC_ADDI = 4'd4;
  localparam logic [3:0] OPC_ST   = 4'd5;
  localparam logic [3:0] OPC_BNZ  = 4'd6;

  // first member is the MSB: pc lands on bit 0
  typedef struct packed {
    logic nxt;
    logic addr;
    logic res;
    logic ops;
    logic instr;
    logic pc;
  } field_mask_t;

  typedef enum logic {ST_CHECK, ST_RECOVER} chk_state_e;
endpackage

// File: rtl/rcc_exec.sv
module rcc_exec
  import rcc_pkg::*;
#(
  parameter int XLEN = 16,
  parameter int PC_W = 8
) (
  input  logic [PC_W-1:0]    pc_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [XLEN-1:0]    a_i,
  input  logic [XLEN-1:0]    b_i,
  output logic [XLEN-1:0]    result_o,
  output logic [XLEN-1:0]    addr_o,
  output logic [PC_W-1:0]    next_pc_o,
  output logic               we_o,
  output logic [REG_AW-1:0]  rd_o
);
  logic [3:0]      opc;
  logic [XLEN-1:0] imm_x;
  logic [PC_W-1:0] imm_p;
  logic [PC_W-1:0] pc_inc;

  assign opc    = instr_i[15:12];
  assign rd_o   = instr_i[11:9];
  assign imm_x  = {{(XLEN-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};
  assign imm_p  = {{(PC_W-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};
  assign pc_inc = pc_i + PC_W'(1);

  always_comb begin
    result_o  = '0;
    addr_o    = '0;
    next_pc_o = pc_inc;
    we_o      = 1'b0;
    case (opc)
      OPC_ADD:  begin result_o = a_i + b_i;   we_o = 1'b1; end
      OPC_SUB:  begin result_o = a_i - b_i;   we_o = 1'b1; end
      OPC_AND:  begin result_o = a_i & b_i;   we_o = 1'b1; end
      OPC_XOR:  begin result_o = a_i ^ b_i;   we_o = 1'b1; end
      OPC_ADDI: begin result_o = a_i + imm_x; we_o = 1'b1; end
      OPC_ST:   begin result_o = b_i; addr_o = a_i; end
      OPC_BNZ:  if (a_i != '0) next_pc_o = pc_i + imm_p;
      default:  ;
    endcase
    if (rd_o == '0) we_o = 1'b0;
  end
endmodule

// File: rtl/rcc_regfile.sv
module rcc_regfile
  import rcc_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] ra_i,
  input  logic [REG_AW-1:0] rb_i,
  output logic [XLEN-1:0]   qa_o,
  output logic [XLEN-1:0]   qb_o,
  input  logic              we_i,
  input  logic [REG_AW-1:0] wa_i,
  input  logic [XLEN-1:0]   wd_i
);
  logic [XLEN-1:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs[i] <= '0;
        else if (we_i && wa_i == REG_AW'(i)) regs[i] <= wd_i;
      end
    end
  end

  assign qa_o = regs[ra_i];
  assign qb_o = regs[rb_i];
endmodule

// File: rtl/rcc_watchdog.sv
module rcc_watchdog #(
  parameter int LIMIT = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic fault_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (kick_i)               cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + CW'(1);
  end

  assign fault_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/rcc_commit_checker.sv
module rcc_commit_checker
  import rcc_pkg::*;
#(
  parameter int XLEN       = 16,
  parameter int PC_W       = 8,
  parameter int WDOG_LIMIT = 256,
  parameter int RESET_PC   = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [PC_W-1:0]    in_pc_i,
  input  logic [INSTR_W-1:0] in_instr_i,
  input  logic [XLEN-1:0]    in_op_a_i,
  input  logic [XLEN-1:0]    in_op_b_i,
  input  logic [XLEN-1:0]    in_result_i,
  input  logic [XLEN-1:0]    in_addr_i,
  input  logic [PC_W-1:0]    in_next_pc_i,
  output logic [PC_W-1:0]    fetch_pc_o,
  input  logic [INSTR_W-1:0] fetch_instr_i,
  output logic               commit_valid_o,
  output logic               commit_we_o,
  output logic [REG_AW-1:0]  commit_rd_o,
  output logic [XLEN-1:0]    commit_data_o,
  output logic               commit_mismatch_o,
  output logic [NFIELDS-1:0] commit_fields_o,
  output logic               restart_o,
  output logic [PC_W-1:0]    restart_pc_o,
  output logic               wdog_fault_o
);
  chk_state_e      state_q;
  logic [PC_W-1:0] pc_q;
  logic            fire;
  logic [XLEN-1:0] rf_a, rf_b, ex_res, ex_addr;
  logic [PC_W-1:0] ex_next;
  logic            ex_we;
  logic [REG_AW-1:0] ex_rd;
  field_mask_t     diff;

  assign in_ready_o = (state_q == ST_CHECK);
  assign fire       = in_valid_i && in_ready_o;
  assign fetch_pc_o = pc_q;

  rcc_regfile #(.XLEN(XLEN)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_i  (fetch_instr_i[8:6]),
    .rb_i  (fetch_instr_i[5:3]),
    .qa_o  (rf_a),
    .qb_o  (rf_b),
    .we_i  (fire && ex_we),
    .wa_i  (ex_rd),
    .wd_i  (ex_res)
  );

  rcc_exec #(.XLEN(XLEN), .PC_W(PC_W)) u_exec (
    .pc_i     (pc_q),
    .instr_i  (fetch_instr_i),
    .a_i      (rf_a),
    .b_i      (rf_b),
    .result_o (ex_res),
    .addr_o   (ex_addr),
    .next_pc_o(ex_next),
    .we_o     (ex_we),
    .rd_o     (ex_rd)
  );

  rcc_watchdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (fire),
    .fault_o(wdog_fault_o)
  );

  always_comb begin
    diff.pc    = (in_pc_i != pc_q);
    diff.instr = (in_instr_i != fetch_instr_i);
    diff.ops   = (in_op_a_i != rf_a) || (in_op_b_i != rf_b);
    diff.res   = (in_result_i != ex_res);
    diff.addr  = (in_addr_i != ex_addr);
    diff.nxt   = (in_next_pc_i != ex_next);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q           <= ST_CHECK;
      pc_q              <= PC_W'(RESET_PC);
      commit_valid_o    <= 1'b0;
      commit_we_o       <= 1'b0;
      commit_rd_o       <= '0;
      commit_data_o     <= '0;
      commit_mismatch_o <= 1'b0;
      commit_fields_o   <= '0;
    end else begin
      commit_valid_o <= fire;
      if (fire) begin
        pc_q              <= ex_next;
        commit_we_o       <= ex_we;
        commit_rd_o       <= ex_rd;
        commit_data_o     <= ex_res;
        commit_mismatch_o <= |diff;
        commit_fields_o   <= diff;
        state_q           <= (|diff) ? ST_RECOVER : ST_CHECK;
      end else begin
        commit_we_o       <= 1'b0;
        commit_mismatch_o <= 1'b0;
        commit_fields_o   <= '0;
        state_q           <= ST_CHECK;
      end
    end
  end

  assign restart_o    = (state_q == ST_RECOVER);
  assign restart_pc_o = pc_q;
endmodule

// File: rtl/rcc_commit_checker_sva.sv
module rcc_commit_checker_sva #(
  parameter int XLEN = 16,
  parameter int PC_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic [PC_W-1:0] fetch_pc_o,
  input logic            commit_valid_o,
  input logic            commit_we_o,
  input logic [2:0]      commit_rd_o,
  input logic            commit_mismatch_o,
  input logic [5:0]      commit_fields_o,
  input logic            restart_o,
  input logic [PC_W-1:0] restart_pc_o,
  input logic            wdog_fault_o
);
  logic fire;
  assign fire = in_valid_i && in_ready_o;

  p_commit_after_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> commit_valid_o);
  p_no_spurious_commit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !commit_valid_o);
  p_r0_not_written_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_we_o |-> (commit_rd_o != 3'd0));
  p_fields_need_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_valid_o |-> (commit_fields_o == 6'd0));
  p_restart_on_mismatch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_o && commit_mismatch_o) |-> restart_o);
  p_restart_blocks_input_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> !in_ready_o);
  p_restart_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);
  p_restart_pc_tracks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> (restart_pc_o == fetch_pc_o));
  p_wdog_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !wdog_fault_o);
endmodule

bind rcc_commit_checker rcc_commit_checker_sva #(.XLEN(XLEN), .PC_W(PC_W)) u_sva (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .in_valid_i       (in_valid_i),
  .in_ready_o       (in_ready_o),
  .fetch_pc_o       (fetch_pc_o),
  .commit_valid_o   (commit_valid_o),
  .commit_we_o      (commit_we_o),
  .commit_rd_o      (commit_rd_o),
  .commit_mismatch_o(commit_mismatch_o),
  .commit_fields_o  (commit_fields_o),
  .restart_o        (restart_o),
  .restart_pc_o     (restart_pc_o),
  .wdog_fault_o     (wdog_fault_o)
);

// File: tb/rcc_commit_checker_tb.sv
module rcc_commit_checker_tb;
  localparam int XLEN = 16;
  localparam int PC_W = 8;
  localparam int WDOG = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [PC_W-1:0] in_pc = '0, in_next = '0;
  logic [15:0]     in_instr = '0;
  logic [XLEN-1:0] in_a = '0, in_b = '0, in_res = '0, in_addr = '0;
  logic [PC_W-1:0] fetch_pc, restart_pc;
  logic [15:0]     fetch_instr;
  logic            c_valid, c_we, c_mis, restart, wdog;
  logic [2:0]      c_rd;
  logic [XLEN-1:0] c_data;
  logic [5:0]      c_fields;

  logic [15:0]     imem [256];
  logic [XLEN-1:0] mrf [8];
  logic [PC_W-1:0] mpc;
  int n_vec = 0, n_bad = 0;

  assign fetch_instr = imem[fetch_pc];

  rcc_commit_checker #(.XLEN(XLEN), .PC_W(PC_W), .WDOG_LIMIT(WDOG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_pc_i(in_pc), .in_instr_i(in_instr), .in_op_a_i(in_a), .in_op_b_i(in_b),
    .in_result_i(in_res), .in_addr_i(in_addr), .in_next_pc_i(in_next),
    .fetch_pc_o(fetch_pc), .fetch_instr_i(fetch_instr),
    .commit_valid_o(c_valid), .commit_we_o(c_we), .commit_rd_o(c_rd),
    .commit_data_o(c_data), .commit_mismatch_o(c_mis), .commit_fields_o(c_fields),
    .restart_o(restart), .restart_pc_o(restart_pc), .wdog_fault_o(wdog)
  );

  task automatic check(string req, string what, longint act, longint expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  function automatic logic [15:0] enc(int op, int rd, int rs1, int lo6);
    return {4'(op), 3'(rd), 3'(rs1), 6'(lo6)};
  endfunction

  // f: -1 none, 0 pc, 1 instr, 2 operands, 3 result, 4 address, 5 next pc
  task automatic send(logic [15:0] ins, int f);
    int op, rd;
    logic [XLEN-1:0] a, b, res, addr, immx;
    logic [PC_W-1:0] nxt;
    bit we;
    op = int'(ins[15:12]);
    rd = int'(ins[11:9]);
    a = mrf[ins[8:6]];
    b = mrf[ins[5:3]];
    immx = XLEN'(signed'(ins[5:0]));
    res = '0; addr = '0; nxt = mpc + 1; we = 0;
    case (op)
      0: begin res = a + b; we = 1; end
      1: begin res = a - b; we = 1; end
      2: begin res = a & b; we = 1; end
      3: begin res = a ^ b; we = 1; end
      4: begin res = a + immx; we = 1; end
      5: begin res = b; addr = a; end
      6: if (a != 0) nxt = mpc + PC_W'(immx);
      default: ;
    endcase
    if (rd == 0) we = 0;
    imem[mpc] = ins;
    while (!in_ready) @(negedge clk);
    in_pc    = (f == 0) ? mpc ^ 8'h01 : mpc;
    in_instr = (f == 1) ? ins ^ 16'h0001 : ins;
    in_a     = (f == 2) ? a ^ 16'h0001 : a;
    in_b     = b;
    in_res   = (f == 3) ? res ^ 16'h0100 : res;
    in_addr  = (f == 4) ? addr ^ 16'h0004 : addr;
    in_next  = (f == 5) ? nxt ^ 8'h02 : nxt;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", "commit_valid", c_valid, 1);
    check("R2", "commit_data", c_data, res);
    check("R3", "commit_we", c_we, we);
    if (we) check("R3", "commit_rd", c_rd, rd);
    check(f < 0 ? "R4" : "R5", "mismatch", c_mis, f >= 0);
    check(f < 0 ? "R4" : "R5", "fields", c_fields, f < 0 ? 0 : (1 << f));
    check("R6", "restart", restart, f >= 0);
    check("R6", "ready", in_ready, f < 0);
    if (f >= 0) check("R6", "restart_pc", restart_pc, nxt);
    if (we) mrf[rd] = res;
    mpc = nxt;
    check("R7", "fetch_pc", fetch_pc, mpc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog timeout");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) imem[i] = '0;
    for (int i = 0; i < 8; i++) mrf[i] = '0;
    mpc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "ready", in_ready, 1);
    check("R9", "commit_valid", c_valid, 0);
    check("R9", "restart", restart, 0);
    check("R9", "wdog", wdog, 0);
    check("R7", "reset pc", fetch_pc, 0);
    // registers start at zero: sum reads back 0
    send(enc(0, 1, 2, 3 << 3), -1);
    check("R9", "r1 after reset", c_data, 0);
    // seed registers and sweep immediates
    for (int imm = 0; imm < 64; imm++)
      send(enc(4, (imm % 7) + 1, imm % 8, imm), -1);
    // write to r0 is dropped: r0 stays zero
    send(enc(4, 0, 1, 5), -1);
    send(enc(0, 2, 0, 0), -1);
    check("R3", "r0 reads zero", c_data, 0);
    // opcode x rd x rs1 x rs2 sweep
    for (int op = 0; op < 16; op++)
      for (int rd = 0; rd < 8; rd++)
        for (int r1 = 0; r1 < 8; r1++)
          for (int r2 = 0; r2 < 8; r2++) begin
            if ((r1 + r2) % 4 == 0)
              send(enc(4, (r1 % 7) + 1, r2, r1 * 5 - 17), -1);
            send(enc(op, rd, r1, r2 << 3), -1);
          end
    // field corruption, each field over several opcodes
    for (int f = 0; f < 6; f++)
      for (int op = 0; op < 8; op++)
        send(enc(op, op % 7 + 1, (op + f) % 8, (f % 8) << 3), f);
    // mismatch at a taken branch restarts at the branch target
    send(enc(4, 3, 0, 7), -1);
    send(enc(6, 0, 3, 6'h3c), 5);
    // watchdog window
    repeat (WDOG - 1) @(negedge clk);
    check("R8", "wdog before limit", wdog, 0);
    @(negedge clk);
    check("R8", "wdog at limit", wdog, 1);
    send(enc(0, 1, 1, 1 << 3), -1);
    check("R8", "wdog cleared", wdog, 0);
    finish_run();
  end
endmodule